// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream DMA Channel

This block is one transmit channel of a scatter-gather DMA engine. Software builds a chain of descriptors in memory. It points the current-descriptor register at the first one and sets run. It then writes the tail-descriptor register. The channel fetches each descriptor over a simple request/response memory port, reads the buffer it names in chunks that fit a small internal store, and sends the words out on a valid/ready stream. It then writes a completion status back into the descriptor and moves to the next one, until the descriptor it has just finished is the tail.

The main concern of the block is memory failure. Every response carries a result code. Any failing response halts the channel at once: on a descriptor fetch, a buffer read or a status write-back. The channel records whether the failure was a decode error or a slave error, drops run, sets halted, and raises an error interrupt that software clears by writing one. While the channel is halted, idle or stopped, it issues no memory request.

Registers: control at 0x00 (bit 0 run, bit 1 error-interrupt enable), status at 0x04 (bit 0 halted, bit 1 idle, bit 4 scatter-gather decode error, bit 5 scatter-gather slave error, bit 8 error interrupt; bits 4, 5 and 8 write-one-to-clear), current descriptor at 0x08 and tail descriptor at 0x10. A descriptor is six little-endian 32-bit words: control at +0 (bits 25:0 byte length, bit 26 end of packet), status at +4, buffer address at +8 (upper half at +12), next pointer at +16 (upper half at +20). The memory result code is 00 for OK, 11 for decode error, and 10 or 01 for slave error.

Top module: `sgdma_channel`

## Requirements
- R1: After reset, status reads 0x003 (halted and idle), control reads 0, current and tail read 0, and irq, mem_req and st_valid are low.
- R2: A descriptor fetch reads the words at +0, +8 and +16 of the current descriptor, in that order. Each request holds its address and direction until its response arrives.
- R3: The buffer words arrive on the stream in address order. No more than CHUNK_WORDS reads are done before the stored words are sent. A beat that is not accepted keeps its data and marker.
- R4: st_last is high only on the final word of a descriptor whose control bit 26 is set.
- R5: After the data of a descriptor has moved, the channel writes the word at +4 with the byte length OR'd with bit 31.
- R6: After a good write-back, current becomes the next pointer of that descriptor. If the finished descriptor equals tail, status bit 1 (idle) is set and work stops.
- R7: A write to tail while run is set clears idle and restarts processing at the current descriptor.
- R8: Any non-OK response clears run and sets halted (bit 0) and error interrupt (bit 8).
- R9: Code 11 sets the decode bit (bit 4). Codes 10 and 01 set the slave bit (bit 5).
- R10: A failing write-back leaves current unchanged.
- R11: Bit 8 is write-one-to-clear. irq is high exactly when bit 8 and control bit 1 are both set, with a lag of one cycle.
- R12: A run write clears halted only when bits 4, 5 and 8 are all clear. Otherwise the channel stays halted.
- R13: No memory request is issued while halted or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_code | input | 2 | Response result code |
| mem_rsp_data | input | 32 | Read data |
| st_valid | output | 1 | Stream beat valid |
| st_data | output | 32 | Stream beat data |
| st_last | output | 1 | End-of-packet marker |
| st_ready | input | 1 | Stream sink ready |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume that the memory gives exactly one response per request, and only while that request is high. They assume that descriptor lengths are multiples of four bytes and that addresses are word aligned. They also assume that software writes current only while halted and writes tail after setting run. The bench model answers each request one cycle after it is seen, then leaves one idle cycle before the next response. It injects an error code only at a single chosen address. It programs registers only in that order, with lengths of 0 mod 4.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  // register byte offsets
  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_CUR  = 6'h08;
  localparam logic [5:0] OFS_TAIL = 6'h10;
  // control bits
  localparam int CTRL_RUN   = 0;
  localparam int CTRL_IRQEN = 1;
  // status bits
  localparam int ST_HALTED  = 0;
  localparam int ST_IDLE    = 1;
  localparam int ST_SG_DEC  = 4;
  localparam int ST_SG_SLV  = 5;
  localparam int ST_ERR_IRQ = 8;
  // descriptor word offsets and fields
  localparam int DW_CTRL = 0;
  localparam int DW_STAT = 4;
  localparam int DW_BUF  = 8;
  localparam int DW_NEXT = 16;
  localparam int DESC_EOP_BIT  = 26;
  localparam int DESC_DONE_BIT = 31;
  // memory result codes
  localparam logic [1:0] RSP_OK     = 2'b00;
  localparam logic [1:0] RSP_DECODE = 2'b11;

  typedef enum logic [2:0] {
    E_IDLE, E_FETCH, E_READ, E_PUSH, E_WB
  } eng_state_t;
endpackage

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 26,
  parameter int CHUNK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_ptr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [1:0]        mem_rsp_code,
  input  logic [31:0]       mem_rsp_data,
  output logic              m_valid,
  output logic              m_last,
  output logic [31:0]       m_data,
  input  logic              m_ready,
  output logic              ev_done,
  output logic              ev_err,
  output logic              ev_dec,
  output logic [ADDR_W-1:0] ev_desc,
  output logic [ADDR_W-1:0] ev_next
);
  localparam int CW = $clog2(CHUNK_WORDS);
  localparam int FW = CW + 1;
  localparam int WL = LEN_W - 2;

  eng_state_t        st;
  logic [1:0]        fidx;
  logic [ADDR_W-1:0] base, baddr, nptr;
  logic [LEN_W-1:0]  len;
  logic              eop;
  logic [WL-1:0]     left;
  logic [FW-1:0]     fill, ridx;
  logic [31:0]       cbuf [CHUNK_WORDS];
  logic              rsp_ok, in_mem;

  assign busy    = (st != E_IDLE);
  assign in_mem  = (st == E_FETCH) || (st == E_READ) || (st == E_WB);
  assign mem_req = in_mem;
  assign mem_we  = (st == E_WB);
  assign rsp_ok  = (mem_rsp_code == RSP_OK);

  always_comb begin
    mem_addr = baddr;
    if (st == E_FETCH) begin
      case (fidx)
        2'd0:    mem_addr = base + ADDR_W'(DW_CTRL);
        2'd1:    mem_addr = base + ADDR_W'(DW_BUF);
        default: mem_addr = base + ADDR_W'(DW_NEXT);
      endcase
    end else if (st == E_WB) begin
      mem_addr = base + ADDR_W'(DW_STAT);
    end
  end

  assign mem_wdata = {{(32-LEN_W){1'b0}}, len} | (32'd1 << DESC_DONE_BIT);
  assign ev_err    = in_mem && mem_rsp_valid && !rsp_ok;
  assign ev_dec    = (mem_rsp_code == RSP_DECODE);
  assign ev_done   = (st == E_WB) && mem_rsp_valid && rsp_ok;
  assign ev_desc   = base;
  assign ev_next   = nptr;

  // chunk store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (st == E_READ && mem_rsp_valid && rsp_ok)
      cbuf[fill[CW-1:0]] <= mem_rsp_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      fidx    <= '0;
      base    <= '0;
      baddr   <= '0;
      nptr    <= '0;
      len     <= '0;
      eop     <= 1'b0;
      left    <= '0;
      fill    <= '0;
      ridx    <= '0;
      m_valid <= 1'b0;
      m_last  <= 1'b0;
      m_data  <= '0;
    end else begin
      case (st)
        E_IDLE: if (go) begin
          base <= start_ptr;
          fidx <= '0;
          fill <= '0;
          st   <= E_FETCH;
        end
        E_FETCH: if (mem_rsp_valid) begin
          if (!rsp_ok) st <= E_IDLE;
          else begin
            fidx <= fidx + 2'd1;
            case (fidx)
              2'd0: begin
                len  <= mem_rsp_data[LEN_W-1:0];
                eop  <= mem_rsp_data[DESC_EOP_BIT];
                left <= mem_rsp_data[LEN_W-1:2];
              end
              2'd1: baddr <= mem_rsp_data[ADDR_W-1:0];
              default: begin
                nptr <= mem_rsp_data[ADDR_W-1:0];
                st   <= (left == '0) ? E_WB : E_READ;
              end
            endcase
          end
        end
        E_READ: if (mem_rsp_valid) begin
          if (!rsp_ok) st <= E_IDLE;
          else begin
            fill  <= fill + FW'(1);
            baddr <= baddr + ADDR_W'(4);
            left  <= left - WL'(1);
            if (fill == FW'(CHUNK_WORDS - 1) || left == WL'(1)) begin
              ridx <= '0;
              st   <= E_PUSH;
            end
          end
        end
        E_PUSH: if (!m_valid || m_ready) begin
          if (ridx != fill) begin
            m_valid <= 1'b1;
            m_data  <= cbuf[ridx[CW-1:0]];
            m_last  <= eop && (left == '0) && (ridx == fill - FW'(1));
            ridx    <= ridx + FW'(1);
          end else begin
            m_valid <= 1'b0;
            m_last  <= 1'b0;
            fill    <= '0;
            st      <= (left == '0) ? E_WB : E_READ;
          end
        end
        E_WB: if (mem_rsp_valid) st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_beat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));
  p_last_gap_r4: assert property (@(posedge clk) disable iff (rst)
    m_valid && m_ready && m_last |=> !m_valid);
endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  input  logic              ev_done,
  input  logic              ev_err,
  input  logic              ev_dec,
  input  logic [ADDR_W-1:0] ev_desc,
  input  logic [ADDR_W-1:0] ev_next,
  output logic              go,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              halted_o,
  output logic              irq
);
  logic              run, irq_en, halted, idle, sg_dec, sg_slv, err_irq;
  logic [ADDR_W-1:0] cur, tail;
  logic [31:0]       stat_v;

  assign go       = run && !halted && !idle;
  assign cur_ptr  = cur;
  assign halted_o = halted;

  always_comb begin
    stat_v             = '0;
    stat_v[ST_HALTED]  = halted;
    stat_v[ST_IDLE]    = idle;
    stat_v[ST_SG_DEC]  = sg_dec;
    stat_v[ST_SG_SLV]  = sg_slv;
    stat_v[ST_ERR_IRQ] = err_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; irq_en <= 1'b0; halted <= 1'b1; idle <= 1'b1;
      sg_dec <= 1'b0; sg_slv <= 1'b0; err_irq <= 1'b0;
      cur <= '0; tail <= '0; reg_rdata <= '0; irq <= 1'b0;
    end else begin
      // a stopped channel reports halted once the engine is quiet
      if (!run && !eng_busy) halted <= 1'b1;
      if (reg_we) begin
        case (reg_addr)
          OFS_CTRL: begin
            run    <= reg_wdata[CTRL_RUN];
            irq_en <= reg_wdata[CTRL_IRQEN];
            if (reg_wdata[CTRL_RUN] && !sg_dec && !sg_slv && !err_irq && !eng_busy)
              halted <= 1'b0;
          end
          OFS_STAT: begin
            if (reg_wdata[ST_SG_DEC])  sg_dec  <= 1'b0;
            if (reg_wdata[ST_SG_SLV])  sg_slv  <= 1'b0;
            if (reg_wdata[ST_ERR_IRQ]) err_irq <= 1'b0;
          end
          OFS_CUR:  if (halted) cur <= reg_wdata[ADDR_W-1:0];
          OFS_TAIL: begin
            tail <= reg_wdata[ADDR_W-1:0];
            if (run) idle <= 1'b0;
          end
          default: ;
        endcase
      end
      if (ev_done) begin
        cur <= ev_next;
        if (ev_desc == tail) idle <= 1'b1;
      end
      if (ev_err) begin
        run     <= 1'b0;
        halted  <= 1'b1;
        err_irq <= 1'b1;
        if (ev_dec) sg_dec <= 1'b1;
        else        sg_slv <= 1'b1;
      end
      irq <= err_irq && irq_en;
      case (reg_addr)
        OFS_CTRL: reg_rdata <= {30'd0, irq_en, run};
        OFS_STAT: reg_rdata <= stat_v;
        OFS_CUR:  reg_rdata <= 32'(cur);
        OFS_TAIL: reg_rdata <= 32'(tail);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  p_err_halt_r8: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> halted && !run && err_irq);
  p_dec_flag_r9: assert property (@(posedge clk) disable iff (rst)
    ev_err && ev_dec |=> sg_dec);
  p_slv_flag_r9: assert property (@(posedge clk) disable iff (rst)
    ev_err && !ev_dec |=> sg_slv);
  p_done_adv_r6: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> cur == $past(ev_next));
endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
  import sgdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 26,
  parameter int CHUNK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [1:0]        mem_rsp_code,
  input  logic [31:0]       mem_rsp_data,
  output logic              st_valid,
  output logic [31:0]       st_data,
  output logic              st_last,
  input  logic              st_ready,
  output logic              irq
);
  logic              go, busy, halted, ev_done, ev_err, ev_dec;
  logic [ADDR_W-1:0] cur_ptr, ev_desc, ev_next;

  sgdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(busy),
    .ev_done(ev_done), .ev_err(ev_err), .ev_dec(ev_dec),
    .ev_desc(ev_desc), .ev_next(ev_next), .go(go), .cur_ptr(cur_ptr),
    .halted_o(halted), .irq(irq)
  );

  sgdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_WORDS(CHUNK_WORDS)) u_eng (
    .clk(clk), .rst(rst), .go(go), .start_ptr(cur_ptr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_code(mem_rsp_code), .mem_rsp_data(mem_rsp_data),
    .m_valid(st_valid), .m_last(st_last), .m_data(st_data), .m_ready(st_ready),
    .ev_done(ev_done), .ev_err(ev_err), .ev_dec(ev_dec),
    .ev_desc(ev_desc), .ev_next(ev_next)
  );

  p_quiet_halted_r13: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_req);
endmodule

// File: tb/sim_sgdma_channel.sv
module sim_sgdma_channel;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [1:0]  mem_rsp_code = 2'b00;
  logic [31:0] mem_rsp_data = '0;
  logic        st_valid, st_last, irq;
  logic [31:0] st_data;
  logic        st_ready = 1'b0;

  always #10 clk = ~clk;

  sgdma_channel u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_code(mem_rsp_code),
    .mem_rsp_data(mem_rsp_data), .st_valid(st_valid), .st_data(st_data),
    .st_last(st_last), .st_ready(st_ready), .irq(irq)
  );

  typedef struct { logic [31:0] data; logic last; } beat_t;
  beat_t       exp_q[$];
  logic [31:0] req_log[$];
  logic [31:0] mem [0:1023];
  int          vecs = 0, fails = 0, req_cnt = 0, cyc = 0;
  logic        bp = 1'b0, inj_on = 1'b0;
  logic [31:0] inj_addr = '0;
  logic [1:0]  inj_code = 2'b00;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  // memory responder: one response per request, one idle cycle between
  initial forever begin
    @(negedge clk);
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    else if (mem_req) begin
      logic [1:0] c;
      c = (inj_on && mem_addr == inj_addr) ? inj_code : 2'b00;
      req_log.push_back(mem_addr);
      req_cnt++;
      if (mem_we) begin
        if (c == 2'b00) mem[mem_addr[11:2]] = mem_wdata;
        mem_rsp_data = '0;
      end else mem_rsp_data = mem[mem_addr[11:2]];
      mem_rsp_code  = c;
      mem_rsp_valid = 1'b1;
    end
  end

  // stream monitor against the scoreboard queue
  initial forever begin
    @(negedge clk);
    cyc++;
    st_ready = bp ? (cyc % 3 != 0) : 1'b1;
    if (st_valid && st_ready) begin
      if (exp_q.size() == 0) begin
        vecs++; fails++;
        $display("FAIL R3 unexpected beat actual=%h expected=none", st_data);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk("R3 beat data", st_data, e.data);
        chk("R4 last marker", 32'(st_last), 32'(e.last));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  task automatic reg_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [5:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_status(logic [31:0] mask, string tag);
    logic [31:0] v;
    int n;
    for (n = 0; n < 3000; n++) begin
      reg_read(6'h04, v);
      if ((v & mask) == mask) break;
    end
    if (n == 3000) chk(tag, v & mask, mask);
  endtask

  task automatic put_desc(int a, int b, int len, bit eop, int nxt);
    mem[a/4]   = 32'(len) | (eop ? 32'h0400_0000 : 32'h0);
    mem[a/4+1] = '0;
    mem[a/4+2] = 32'(b);
    mem[a/4+3] = '0;
    mem[a/4+4] = 32'(nxt);
    mem[a/4+5] = '0;
  endtask

  task automatic expect_beats(int b, int len, bit eop);
    for (int i = 0; i < len / 4; i++) begin
      beat_t e;
      e.data = mem[b/4 + i];
      e.last = eop && (i == len / 4 - 1);
      exp_q.push_back(e);
    end
  endtask

  task automatic quiet(string tag);
    int c0;
    c0 = req_cnt;
    repeat (20) @(negedge clk);
    chk(tag, 32'(req_cnt), 32'(c0));
  endtask

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + 32'(i * 7);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 st_valid", 32'(st_valid), 0);
    reg_read(6'h04, v); chk("R1 status", v, 32'h003);
    reg_read(6'h00, v); chk("R1 control", v, 0);
    reg_read(6'h08, v); chk("R1 current", v, 0);

    // two-descriptor chain, backpressure on the stream
    put_desc(32'h100, 32'h400, 24, 1'b0, 32'h140);
    put_desc(32'h140, 32'h500, 8, 1'b1, 32'h180);
    expect_beats(32'h400, 24, 1'b0);
    expect_beats(32'h500, 8, 1'b1);
    bp = 1'b1;
    reg_write(6'h08, 32'h100);
    reg_write(6'h00, 32'h3);
    reg_read(6'h04, v); chk("R13 idle until tail written", v, 32'h002);
    quiet("R13 no request while idle");
    base = req_log.size();
    reg_write(6'h10, 32'h140);
    wait_status(32'h002, "R6 idle after tail");
    chk("R2 fetch control word", req_log[base], 32'h100);
    chk("R2 fetch buffer word", req_log[base+1], 32'h108);
    chk("R2 fetch next word", req_log[base+2], 32'h110);
    chk("R5 write-back first", mem[32'h104/4], 32'h8000_0018);
    chk("R5 write-back second", mem[32'h144/4], 32'h8000_0008);
    reg_read(6'h04, v); chk("R6 status idle", v, 32'h002);
    reg_read(6'h08, v); chk("R6 current follows next", v, 32'h180);
    chk("R3 all beats sent", 32'(exp_q.size()), 0);
    quiet("R13 no request after tail reached");

    // R7 tail write restarts
    put_desc(32'h180, 32'h580, 4, 1'b1, 32'h1C0);
    expect_beats(32'h580, 4, 1'b1);
    reg_write(6'h10, 32'h180);
    wait_status(32'h002, "R7 idle again");
    chk("R7 restarted descriptor written back", mem[32'h184/4], 32'h8000_0004);
    reg_read(6'h08, v); chk("R7 current advanced", v, 32'h1C0);
    chk("R7 beat sent", 32'(exp_q.size()), 0);

    // R8 R9 decode error on a buffer read
    put_desc(32'h1C0, 32'h600, 16, 1'b1, 32'h200);
    inj_on = 1'b1; inj_addr = 32'h604; inj_code = 2'b11;
    reg_write(6'h10, 32'h1C0);
    wait_status(32'h101, "R8 halt on read error");
    reg_read(6'h04, v); chk("R9 decode bits", v, 32'h111);
    reg_read(6'h00, v); chk("R8 run cleared", v, 32'h2);
    repeat (2) @(negedge clk);
    chk("R11 irq raised", 32'(irq), 1);
    reg_read(6'h08, v); chk("R8 current kept", v, 32'h1C0);
    quiet("R13 no request while halted");
    chk("R3 no partial chunk sent", 32'(exp_q.size()), 0);

    // R12 run without clearing errors stays halted
    reg_write(6'h00, 32'h3);
    reg_read(6'h04, v); chk("R12 still halted", v, 32'h111);
    quiet("R12 no request");
    reg_write(6'h04, 32'h130);
    repeat (2) @(negedge clk);
    chk("R11 irq cleared", 32'(irq), 0);
    reg_read(6'h04, v); chk("R11 w1c status", v, 32'h001);

    // R9 slave error (10) on descriptor fetch
    inj_addr = 32'h1C0; inj_code = 2'b10;
    reg_write(6'h00, 32'h3);
    wait_status(32'h101, "R8 halt on fetch error");
    reg_read(6'h04, v); chk("R9 slave bits code 10", v, 32'h121);

    // R10 code 01 on write-back, interrupt disabled
    reg_write(6'h04, 32'h130);
    inj_addr = 32'h1C4; inj_code = 2'b01;
    bp = 1'b0;
    expect_beats(32'h600, 16, 1'b1);
    reg_write(6'h00, 32'h1);
    wait_status(32'h101, "R8 halt on write-back error");
    reg_read(6'h04, v); chk("R9 slave bits code 01", v, 32'h121);
    reg_read(6'h08, v); chk("R10 current not advanced", v, 32'h1C0);
    chk("R4 beats before failed write-back", 32'(exp_q.size()), 0);
    repeat (2) @(negedge clk);
    chk("R11 irq masked", 32'(irq), 0);

    report();
    $finish;
  end
endmodule